// File: doc/BRIEF.md
# Load Memory Issue Controller

This block sits between a load queue and the request side of a data cache. Each cycle it may take one executing load descriptor and turn it into one or two cache requests. It applies the issue rules for uncacheable and load-locked accesses, and it budgets the cache ports available in the cycle. Loads that straddle a line boundary are split into two requests. The block tracks how many responses each such load still awaits. When the cache refuses a load, the oldest refused load is kept as a blocked report for the pipeline to act on.

The cache accepts or refuses each request lane in the same cycle through a per-lane accept bit. A refused first request means the cache is blocked for that load. A refused second half of a split load leaves only the first half in flight and raises a retry pulse. When no port is left, the producer must keep presenting the same descriptor until the ready output rises.

Top module: `load_issue_ctrl`

## Requirements
- R1: An uncacheable load produces a request only when its index equals the queue head index and its at-commit flag is set. Any other uncacheable load is consumed with no request, and `ld_resched` and `ld_fault` are high in that same cycle.
- R2: The command code is 2 for a load-locked request and 1 for a plain read. A lane that carries no request shows 0.
- R3: `ports_used` equals the number of request lanes valid in the cycle and never exceeds NPORTS. A split load whose halves both issue in one cycle uses two ports. Lane 0 is filled before lane 1.
- R4: When no port is left in the cycle, a valid load is held. `ld_ready` is low and the load issues no request. The same descriptor is taken in a later cycle.
- R5: A split load's first request goes to the load address with size LINE_BYTES minus the address offset within the line. The second request goes to the next line boundary with the remaining bytes.
- R6: An accepted split load awaits two responses. `done_valid` with its index rises only on the response that brings its count to zero. A non-split load completes on its single response.
- R7: If the first request is refused, no second half is sent, either at once or later. Nothing stays outstanding for that load, so a later response for it gives no `done_valid`.
- R8: If only the second half is refused, `retry` is high in that cycle. The load then awaits one response, and that response completes it.
- R9: A refused first request records the load's sequence number as blocked and clears the handled flag, unless an older (smaller) sequence number is already recorded. In that case the record is unchanged.
- R10: `blk_clear` drops `blk_valid`. `blk_mark_handled` sets `blk_handled` and leaves `blk_seq` unchanged.
- R11: `lq_full` is high exactly when `lq_count` is at least LQ_DEPTH minus one.
- R12: A split second half that finds no free port is sent on lane 0 in the next cycle, ahead of any new load.
- R13: After reset no lane is valid, `blk_valid` and `blk_handled` are low, and `ports_used` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load descriptor present |
| ld_idx | input | IDX_W | Load queue index of the load |
| ld_seq | input | SEQ_W | Age tag, smaller is older |
| ld_addr | input | ADDR_W | Byte address |
| ld_size | input | SIZE_W | Access size in bytes |
| ld_uncached | input | 1 | Uncacheable access |
| ld_split | input | 1 | Access crosses a line boundary |
| ld_locked | input | 1 | Load-locked access |
| ld_at_commit | input | 1 | Load is at the commit point |
| lq_head | input | IDX_W | Current load queue head index |
| lq_count | input | IDX_W+1 | Load queue occupancy |
| ld_ready | output | 1 | Descriptor consumed this cycle |
| ld_resched | output | 1 | Load must be rescheduled |
| ld_fault | output | 1 | Uncacheable issue-rule fault |
| req_valid | output | 2 | Request valid per lane |
| req_cmd | output | 4 | Command per lane, 2 bits each |
| req_addr | output | 2*ADDR_W | Address per lane |
| req_size | output | 2*SIZE_W | Size per lane |
| req_idx | output | 2*IDX_W | Load index per lane |
| req_acc | input | 2 | Cache accepts the lane this cycle |
| ports_used | output | 2 | Ports used this cycle |
| retry | output | 1 | Second half refused |
| rsp_valid | input | 1 | Response beat |
| rsp_idx | input | IDX_W | Load index of the response |
| done_valid | output | 1 | Load fully answered |
| done_idx | output | IDX_W | Index of the finished load |
| blk_mark_handled | input | 1 | Mark blocked report handled |
| blk_clear | input | 1 | Drop blocked report |
| blk_valid | output | 1 | Blocked report present |
| blk_seq | output | SEQ_W | Age tag of the blocked load |
| blk_handled | output | 1 | Blocked report handled |
| lq_full | output | 1 | Load queue full |

## Verification
The bench builds two copies that share all stimulus, one with NPORTS at 2 and one with NPORTS at 1, both with an 8-entry queue and 16-byte lines. The two-port copy shows both halves of a split load issuing in one cycle. It also carries the refusal cases, the response counting and the blocked-record ordering. The single-port copy is the only one that can run out of ports. It exposes the deferred second half on lane 0 and the holding of a new load behind it.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_READ   = 2'd1,
    CMD_LOCKED = 2'd2
  } lic_cmd_e;
endpackage

// File: rtl/lic_lane_alloc.sv
module lic_lane_alloc
  import lic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 5,
  parameter int IDX_W      = 3,
  parameter int LINE_BYTES = 16,
  parameter int NPORTS     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  want,
  input  logic [IDX_W-1:0]      ld_idx,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [SIZE_W-1:0]     ld_size,
  input  logic                  ld_split,
  input  logic                  ld_locked,
  input  logic [1:0]            req_acc,
  output logic                  held,
  output logic                  first_acc,
  output logic                  first_rej,
  output logic                  sec_rej,
  output logic [IDX_W-1:0]      sec_rej_idx,
  output logic                  stash,
  output logic [1:0]            ports_used,
  output logic [1:0]            req_valid,
  output logic [3:0]            req_cmd,
  output logic [2*ADDR_W-1:0]   req_addr,
  output logic [2*SIZE_W-1:0]   req_size,
  output logic [2*IDX_W-1:0]    req_idx
);
  localparam int          OFF_W  = $clog2(LINE_BYTES);
  localparam logic [OFF_W:0] LINE_L = LINE_BYTES[OFF_W:0];
  localparam logic [1:0]  NP     = NPORTS[1:0];

  function automatic logic [SIZE_W-1:0] first_part(input logic [ADDR_W-1:0] a,
                                                   input logic [SIZE_W-1:0] s,
                                                   input logic sp);
    logic [OFF_W:0] room;
    room = LINE_L - {1'b0, a[OFF_W-1:0]};
    return sp ? SIZE_W'(room) : s;
  endfunction

  function automatic logic [ADDR_W-1:0] line_after(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};
  endfunction

  logic                 pend_v;
  logic [IDX_W-1:0]     pend_idx;
  logic [ADDR_W-1:0]    pend_addr;
  logic [SIZE_W-1:0]    pend_size;
  lic_cmd_e             pend_cmd;

  lic_cmd_e             new_cmd;
  logic [SIZE_W-1:0]    lo_sz;
  logic [ADDR_W-1:0]    hi_ad;
  logic [SIZE_W-1:0]    hi_sz;
  logic [1:0]           used;
  logic                 k;

  assign new_cmd = ld_locked ? CMD_LOCKED : CMD_READ;
  assign lo_sz   = first_part(ld_addr, ld_size, ld_split);
  assign hi_ad   = line_after(ld_addr);
  assign hi_sz   = ld_size - lo_sz;

  always_comb begin
    used        = 2'd0;
    k           = 1'b0;
    held        = 1'b0;
    first_acc   = 1'b0;
    first_rej   = 1'b0;
    sec_rej     = 1'b0;
    sec_rej_idx = ld_idx;
    stash       = 1'b0;
    req_valid   = 2'b00;
    req_cmd     = '0;
    req_addr    = '0;
    req_size    = '0;
    req_idx     = '0;
    if (pend_v) begin
      req_valid[0]          = 1'b1;
      req_cmd[1:0]          = pend_cmd;
      req_addr[ADDR_W-1:0]  = pend_addr;
      req_size[SIZE_W-1:0]  = pend_size;
      req_idx[IDX_W-1:0]    = pend_idx;
      used                  = 2'd1;
      if (!req_acc[0]) begin
        sec_rej     = 1'b1;
        sec_rej_idx = pend_idx;
      end
    end
    if (want) begin
      if (used >= NP) begin
        held = 1'b1;
      end else begin
        k                          = used[0];
        req_valid[k]               = 1'b1;
        req_cmd[k*2 +: 2]          = new_cmd;
        req_addr[k*ADDR_W +: ADDR_W] = ld_addr;
        req_size[k*SIZE_W +: SIZE_W] = lo_sz;
        req_idx[k*IDX_W +: IDX_W]  = ld_idx;
        used                       = used + 2'd1;
        if (!req_acc[k]) begin
          first_rej = 1'b1;
        end else begin
          first_acc = 1'b1;
          if (ld_split) begin
            if (used < NP) begin
              req_valid[1]                 = 1'b1;
              req_cmd[3:2]                 = new_cmd;
              req_addr[ADDR_W +: ADDR_W]   = hi_ad;
              req_size[SIZE_W +: SIZE_W]   = hi_sz;
              req_idx[IDX_W +: IDX_W]      = ld_idx;
              used                         = used + 2'd1;
              if (!req_acc[1]) begin
                sec_rej     = 1'b1;
                sec_rej_idx = ld_idx;
              end
            end else begin
              stash = 1'b1;
            end
          end
        end
      end
    end
    ports_used = used;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_addr <= '0;
      pend_size <= '0;
      pend_cmd  <= CMD_NONE;
    end else if (stash) begin
      pend_v    <= 1'b1;
      pend_idx  <= ld_idx;
      pend_addr <= hi_ad;
      pend_size <= hi_sz;
      pend_cmd  <= new_cmd;
    end else begin
      pend_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/lic_outstanding.sv
module lic_outstanding #(
  parameter int LQ_DEPTH = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_v,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [1:0]       set_cnt,
  input  logic             dec_v,
  input  logic [IDX_W-1:0] dec_idx,
  input  logic             rsp_v,
  input  logic [IDX_W-1:0] rsp_idx,
  output logic             done_v,
  output logic [IDX_W-1:0] done_idx
);
  logic [1:0] cnt [LQ_DEPTH];

  for (genvar e = 0; e < LQ_DEPTH; e++) begin : g_ent
    logic [1:0] c;
    logic [1:0] nxt;
    always_comb begin
      nxt = c;
      if (rsp_v && rsp_idx == IDX_W'(e) && nxt != 2'd0) nxt = nxt - 2'd1;
      if (set_v && set_idx == IDX_W'(e)) nxt = set_cnt;
      if (dec_v && dec_idx == IDX_W'(e) && nxt != 2'd0) nxt = nxt - 2'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c <= 2'd0;
      else        c <= nxt;
    end
    assign cnt[e] = c;
  end

  assign done_v   = rsp_v && (cnt[rsp_idx] == 2'd1);
  assign done_idx = rsp_idx;
endmodule

// File: rtl/lic_block_rec.sv
module lic_block_rec #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_v,
  input  logic [SEQ_W-1:0] rec_seq,
  input  logic             clr,
  input  logic             mark,
  output logic             blk_v,
  output logic [SEQ_W-1:0] blk_seq,
  output logic             blk_hnd
);
  logic take;
  assign take = rec_v && (!blk_v || rec_seq <= blk_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_v   <= 1'b0;
      blk_seq <= '0;
      blk_hnd <= 1'b0;
    end else if (take) begin
      blk_v   <= 1'b1;
      blk_seq <= rec_seq;
      blk_hnd <= 1'b0;
    end else begin
      if (clr)  blk_v   <= 1'b0;
      if (mark) blk_hnd <= 1'b1;
    end
  end
endmodule

// File: rtl/load_issue_ctrl.sv
module load_issue_ctrl #(
  parameter int LQ_DEPTH   = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 5,
  parameter int LINE_BYTES = 16,
  parameter int NPORTS     = 2,
  localparam int IDX_W     = $clog2(LQ_DEPTH),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic [SEQ_W-1:0]     ld_seq,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [SIZE_W-1:0]    ld_size,
  input  logic                 ld_uncached,
  input  logic                 ld_split,
  input  logic                 ld_locked,
  input  logic                 ld_at_commit,
  input  logic [IDX_W-1:0]     lq_head,
  input  logic [CNT_W-1:0]     lq_count,
  output logic                 ld_ready,
  output logic                 ld_resched,
  output logic                 ld_fault,
  output logic [1:0]           req_valid,
  output logic [3:0]           req_cmd,
  output logic [2*ADDR_W-1:0]  req_addr,
  output logic [2*SIZE_W-1:0]  req_size,
  output logic [2*IDX_W-1:0]   req_idx,
  input  logic [1:0]           req_acc,
  output logic [1:0]           ports_used,
  output logic                 retry,
  input  logic                 rsp_valid,
  input  logic [IDX_W-1:0]     rsp_idx,
  output logic                 done_valid,
  output logic [IDX_W-1:0]     done_idx,
  input  logic                 blk_mark_handled,
  input  logic                 blk_clear,
  output logic                 blk_valid,
  output logic [SEQ_W-1:0]     blk_seq,
  output logic                 blk_handled,
  output logic                 lq_full
);
  localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(LQ_DEPTH - 1);

  function automatic logic uc_blocked(input logic uc, input logic [IDX_W-1:0] idx,
                                      input logic [IDX_W-1:0] head, input logic at_c);
    return uc && !(idx == head && at_c);
  endfunction

  logic             uc_gate_fail;
  logic             want;
  logic             held;
  logic             first_acc;
  logic             first_rej;
  logic             sec_rej;
  logic [IDX_W-1:0] sec_rej_idx;
  logic             stash;

  assign uc_gate_fail = ld_valid && uc_blocked(ld_uncached, ld_idx, lq_head, ld_at_commit);
  assign want         = ld_valid && !uc_gate_fail;
  assign ld_ready     = !held;
  assign ld_resched   = uc_gate_fail;
  assign ld_fault     = uc_gate_fail;
  assign retry        = sec_rej;
  assign lq_full      = (lq_count >= FULL_AT);

  lic_lane_alloc #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W),
    .LINE_BYTES(LINE_BYTES), .NPORTS(NPORTS)
  ) u_lanes (
    .clk(clk), .rst_n(rst_n), .want(want),
    .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_split(ld_split), .ld_locked(ld_locked), .req_acc(req_acc),
    .held(held), .first_acc(first_acc), .first_rej(first_rej),
    .sec_rej(sec_rej), .sec_rej_idx(sec_rej_idx), .stash(stash),
    .ports_used(ports_used), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_size(req_size), .req_idx(req_idx)
  );

  lic_outstanding #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_outst (
    .clk(clk), .rst_n(rst_n),
    .set_v(first_acc), .set_idx(ld_idx), .set_cnt(ld_split ? 2'd2 : 2'd1),
    .dec_v(sec_rej), .dec_idx(sec_rej_idx),
    .rsp_v(rsp_valid), .rsp_idx(rsp_idx),
    .done_v(done_valid), .done_idx(done_idx)
  );

  lic_block_rec #(.SEQ_W(SEQ_W)) u_blk (
    .clk(clk), .rst_n(rst_n),
    .rec_v(first_rej), .rec_seq(ld_seq),
    .clr(blk_clear), .mark(blk_mark_handled),
    .blk_v(blk_valid), .blk_seq(blk_seq), .blk_hnd(blk_handled)
  );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int SEQ_W  = 16,
  parameter int NPORTS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             ld_fault,
  input logic [SEQ_W-1:0] ld_seq,
  input logic [1:0]       req_valid,
  input logic [1:0]       ports_used,
  input logic             first_acc,
  input logic             first_rej,
  input logic             stash,
  input logic             rsp_valid,
  input logic             done_valid,
  input logic             blk_mark_handled,
  input logic             blk_valid,
  input logic [SEQ_W-1:0] blk_seq,
  input logic             blk_handled
);
  localparam logic [1:0] NP = NPORTS[1:0];

  AST_PORT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ports_used <= NP); // R3
  AST_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ports_used == 2'($countones(req_valid))); // R3
  AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |-> ports_used == NP); // R4
  AST_UC_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> (ld_ready && !first_acc && !first_rej)); // R1
  AST_DEFER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    stash |=> req_valid[0]); // R12
  AST_REJ_NO_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    first_rej |-> !stash); // R7
  AST_DONE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> rsp_valid); // R6
  AST_YOUNGER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && first_rej && ld_seq > blk_seq) |=> $stable(blk_seq)); // R9
  AST_REC_CLR_HND: assert property (@(posedge clk) disable iff (!rst_n)
    (first_rej && !blk_valid) |=> (blk_valid && !blk_handled)); // R9
  AST_HND_KEEPS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mark_handled && !first_rej) |=> (blk_handled && $stable(blk_seq))); // R10
endmodule

bind load_issue_ctrl lic_checker #(.SEQ_W(SEQ_W), .NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_fault(ld_fault), .ld_seq(ld_seq), .req_valid(req_valid),
  .ports_used(ports_used), .first_acc(first_acc), .first_rej(first_rej),
  .stash(stash), .rsp_valid(rsp_valid), .done_valid(done_valid),
  .blk_mark_handled(blk_mark_handled), .blk_valid(blk_valid),
  .blk_seq(blk_seq), .blk_handled(blk_handled)
);

// File: tb/load_issue_ctrl_tb_top.sv
module load_issue_ctrl_tb_top;
  localparam int AW = 32;
  localparam int SW = 5;
  localparam int IW = 3;
  localparam int QW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ld_valid = 0, ld_uncached = 0, ld_split = 0, ld_locked = 0, ld_at_commit = 0;
  logic [IW-1:0] ld_idx = 0, lq_head = 0, rsp_idx = 0;
  logic [QW-1:0] ld_seq = 0;
  logic [AW-1:0] ld_addr = 0;
  logic [SW-1:0] ld_size = 0;
  logic [IW:0]   lq_count = 0;
  logic [1:0]    req_acc = 2'b11;
  logic          rsp_valid = 0, blk_mark_handled = 0, blk_clear = 0;

  logic          rdy, rsch, flt, rtr, dn, bv, bh, full;
  logic [1:0]    rv, pu;
  logic [3:0]    rc;
  logic [2*AW-1:0] ra;
  logic [2*SW-1:0] rs;
  logic [2*IW-1:0] ri;
  logic [IW-1:0] dni;
  logic [QW-1:0] bs;

  logic          rdy1, rsch1, flt1, rtr1, dn1, bv1, bh1, full1;
  logic [1:0]    rv1, pu1;
  logic [3:0]    rc1;
  logic [2*AW-1:0] ra1;
  logic [2*SW-1:0] rs1;
  logic [2*IW-1:0] ri1;
  logic [IW-1:0] dni1;
  logic [QW-1:0] bs1;

  load_issue_ctrl #(.NPORTS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_seq(ld_seq),
    .ld_addr(ld_addr), .ld_size(ld_size), .ld_uncached(ld_uncached), .ld_split(ld_split),
    .ld_locked(ld_locked), .ld_at_commit(ld_at_commit), .lq_head(lq_head), .lq_count(lq_count),
    .ld_ready(rdy), .ld_resched(rsch), .ld_fault(flt), .req_valid(rv), .req_cmd(rc),
    .req_addr(ra), .req_size(rs), .req_idx(ri), .req_acc(req_acc), .ports_used(pu),
    .retry(rtr), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .done_valid(dn), .done_idx(dni),
    .blk_mark_handled(blk_mark_handled), .blk_clear(blk_clear), .blk_valid(bv),
    .blk_seq(bs), .blk_handled(bh), .lq_full(full)
  );

  load_issue_ctrl #(.NPORTS(1)) dut_n1_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_seq(ld_seq),
    .ld_addr(ld_addr), .ld_size(ld_size), .ld_uncached(ld_uncached), .ld_split(ld_split),
    .ld_locked(ld_locked), .ld_at_commit(ld_at_commit), .lq_head(lq_head), .lq_count(lq_count),
    .ld_ready(rdy1), .ld_resched(rsch1), .ld_fault(flt1), .req_valid(rv1), .req_cmd(rc1),
    .req_addr(ra1), .req_size(rs1), .req_idx(ri1), .req_acc(req_acc), .ports_used(pu1),
    .retry(rtr1), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .done_valid(dn1), .done_idx(dni1),
    .blk_mark_handled(blk_mark_handled), .blk_clear(blk_clear), .blk_valid(bv1),
    .blk_seq(bs1), .blk_handled(bh1), .lq_full(full1)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ld_valid = 0; ld_uncached = 0; ld_split = 0; ld_locked = 0; ld_at_commit = 0;
    rsp_valid = 0; blk_mark_handled = 0; blk_clear = 0; req_acc = 2'b11;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic load(input logic [IW-1:0] i, input logic [QW-1:0] q,
                      input logic [AW-1:0] a, input logic [SW-1:0] s, input logic sp);
    ld_valid = 1; ld_idx = i; ld_seq = q; ld_addr = a; ld_size = s; ld_split = sp;
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R13 req_valid", 64'(rv), 64'd0);
    chk("R13 blk_valid", 64'(bv), 64'd0);
    chk("R13 blk_handled", 64'(bh), 64'd0);
    chk("R13 ports_used", 64'(pu), 64'd0);
  endtask

  task automatic t_plain_cmds();
    do_reset();
    step(); load(3'd3, 16'd1, 32'h100, 5'd4, 0);
    #2;
    chk("R2 read cmd", 64'(rc[1:0]), 64'd1);
    chk("R3 one port", 64'(pu), 64'd1);
    chk("R3 lane0 only", 64'(rv), 64'b01);
    chk("R2 lane1 idle cmd", 64'(rc[3:2]), 64'd0);
    chk("R3 lane0 addr", 64'(ra[AW-1:0]), 64'h100);
    step(); ld_locked = 1;
    #2;
    chk("R2 locked cmd", 64'(rc[1:0]), 64'd2);
    step(); idle_inputs();
    rsp_valid = 1; rsp_idx = 3'd3;
    #2;
    chk("R6 single done", 64'(dn), 64'd1);
    step(); idle_inputs();
  endtask

  task automatic t_uncached();
    do_reset();
    lq_head = 3'd2;
    step(); load(3'd3, 16'd2, 32'h40, 5'd4, 0); ld_uncached = 1; ld_at_commit = 1;
    #2;
    chk("R1 not head resched", 64'(rsch), 64'd1);
    chk("R1 not head fault", 64'(flt), 64'd1);
    chk("R1 not head no req", 64'(rv), 64'd0);
    chk("R1 consumed", 64'(rdy), 64'd1);
    step(); ld_idx = 3'd2; ld_at_commit = 0;
    #2;
    chk("R1 not commit resched", 64'(rsch), 64'd1);
    chk("R1 not commit no req", 64'(rv), 64'd0);
    step(); ld_at_commit = 1;
    #2;
    chk("R1 head commit issues", 64'(rv), 64'b01);
    chk("R1 head commit no fault", 64'(flt), 64'd0);
    step(); idle_inputs();
  endtask

  task automatic t_split();
    do_reset();
    step(); load(3'd4, 16'd5, 32'h10C, 5'd8, 1);
    #2;
    chk("R3 split two lanes", 64'(rv), 64'b11);
    chk("R3 split two ports", 64'(pu), 64'd2);
    chk("R5 lo addr", 64'(ra[AW-1:0]), 64'h10C);
    chk("R5 lo size", 64'(rs[SW-1:0]), 64'd4);
    chk("R5 hi addr", 64'(ra[2*AW-1:AW]), 64'h110);
    chk("R5 hi size", 64'(rs[2*SW-1:SW]), 64'd4);
    step(); idle_inputs(); rsp_valid = 1; rsp_idx = 3'd4;
    #2;
    chk("R6 first rsp no done", 64'(dn), 64'd0);
    step();
    #2;
    chk("R6 second rsp done", 64'(dn), 64'd1);
    chk("R6 done idx", 64'(dni), 64'd4);
    step(); idle_inputs();
  endtask

  task automatic t_second_rej();
    do_reset();
    step(); load(3'd5, 16'd7, 32'h1FC, 5'd8, 1); req_acc = 2'b01;
    #2;
    chk("R8 retry", 64'(rtr), 64'd1);
    chk("R8 consumed", 64'(rdy), 64'd1);
    step(); idle_inputs(); rsp_valid = 1; rsp_idx = 3'd5;
    #2;
    chk("R8 single rsp completes", 64'(dn), 64'd1);
    step(); idle_inputs();
  endtask

  task automatic t_block();
    do_reset();
    step(); load(3'd6, 16'd20, 32'h20C, 5'd8, 1); req_acc = 2'b00;
    #2;
    chk("R7 no second lane", 64'(rv), 64'b01);
    chk("R7 no retry", 64'(rtr), 64'd0);
    step(); idle_inputs();
    #2;
    chk("R9 recorded", 64'(bv), 64'd1);
    chk("R9 seq", 64'(bs), 64'd20);
    chk("R9 handled cleared", 64'(bh), 64'd0);
    chk("R7 no deferred half", 64'(rv1), 64'd0);
    rsp_valid = 1; rsp_idx = 3'd6;
    #2;
    chk("R7 no done", 64'(dn), 64'd0);
    step(); idle_inputs(); blk_mark_handled = 1;
    step(); idle_inputs();
    #2;
    chk("R10 handled set", 64'(bh), 64'd1);
    chk("R10 seq kept", 64'(bs), 64'd20);
    load(3'd1, 16'd30, 32'h80, 5'd4, 0); req_acc = 2'b00;
    step(); idle_inputs();
    #2;
    chk("R9 younger ignored", 64'(bs), 64'd20);
    chk("R9 younger keeps handled", 64'(bh), 64'd1);
    load(3'd2, 16'd10, 32'h90, 5'd4, 0); req_acc = 2'b00;
    step(); idle_inputs();
    #2;
    chk("R9 older replaces", 64'(bs), 64'd10);
    chk("R9 older clears handled", 64'(bh), 64'd0);
    blk_clear = 1;
    step(); idle_inputs();
    #2;
    chk("R10 cleared", 64'(bv), 64'd0);
  endtask

  task automatic t_one_port();
    do_reset();
    step(); load(3'd1, 16'd3, 32'h20C, 5'd8, 1);
    #2;
    chk("R3 single port lane0", 64'(rv1), 64'b01);
    chk("R3 single port used", 64'(pu1), 64'd1);
    step(); load(3'd2, 16'd9, 32'h300, 5'd4, 0);
    #2;
    chk("R4 held", 64'(rdy1), 64'd0);
    chk("R12 deferred addr", 64'(ra1[AW-1:0]), 64'h210);
    chk("R12 deferred size", 64'(rs1[SW-1:0]), 64'd4);
    chk("R12 deferred idx", 64'(ri1[IW-1:0]), 64'd1);
    step();
    #2;
    chk("R4 taken later", 64'(rdy1), 64'd1);
    chk("R4 new load addr", 64'(ra1[AW-1:0]), 64'h300);
    step(); idle_inputs();
  endtask

  task automatic t_full();
    lq_count = 4'd6;
    #2;
    chk("R11 not full", 64'(full), 64'd0);
    lq_count = 4'd7;
    #2;
    chk("R11 full", 64'(full), 64'd1);
    lq_count = 4'd8;
    #2;
    chk("R11 above", 64'(full), 64'd1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_cmds();
    t_uncached();
    t_split();
    t_second_rej();
    t_block();
    t_one_port();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule